// File: doc/BRIEF.md
# Load Queue Ordering Violation Detector

This block keeps the in-flight loads of an out-of-order core in a circular queue, in program order, and watches for memory-ordering hazards. Each load receives a sequence number and notes where the store queue stood when the load entered. Once the load has computed its address, the core posts that address into the load's slot.

When a load or a store executes, the core presents a check request with a starting queue index and the access address. The block compares the address with every younger load that already holds a valid address, using a coarse match on the bits above the lowest eight. The youngest-side scan picks the oldest matching load. If that load is older than any violator already held, it becomes the new violator and a fault pulse is raised, so the core can squash and refetch from it. Commit retires loads from the head by sequence-number bound. Squash trims loads from the tail. Reading the violator clears it.

Top module: `ldq_order_guard`

## Requirements
- R1: After reset the queue is empty (count 0, not full, allocation index 0), no violator is held, the fault pulse is low and the violation counter is 0.
- R2: The queue holds at most DEPTH loads in a ring of DEPTH+1 slots. `lqFull` is high when DEPTH loads are held. An allocation while full is ignored, so count and tail stay the same.
- R3: An accepted allocation writes the load at the slot shown on `allocIdx` and records `sqTail` as its store index. When `sqEmpty` is high it records a none marker instead. `headSqNone`/`headSqIdx` show the record of the oldest held load.
- R4: A load check (`chkIsStore`=0) scans the loads from the slot after `chkIdx` up to, but not including, the tail. The checking load itself and older loads never match.
- R5: A store check (`chkIsStore`=1) scans from `chkIdx` itself (the load tail captured when the store was allocated) up to, but not including, the current tail.
- R6: A scanned load matches only when its address has been posted since allocation and its address bits above bit 7 equal those of `chkAddr`. Addresses that differ only in bits 7:0 match.
- R7: Of the matching loads, only the first one in scan order (the oldest) is considered. It replaces the held violator when none is held or when its sequence number is smaller. Otherwise the check reports nothing.
- R8: A check that records a violator raises `chkFault` for exactly one cycle, in the cycle after the check, and `violCount` increments by one at the same edge.
- R9: A commit removes, in one cycle, every head load whose sequence number is not above `commitSeq`.
- R10: A squash removes, in one cycle, every tail load whose sequence number is above `squashSeq`. It clears the held violator when `squashSeq` is below the violator's sequence number.
- R11: `violRead` clears the held violator at the next edge. A detection in the same cycle takes priority, and the new violator stays held.
- R12: In a squash cycle, allocation, commit and the check are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocValid | input | 1 | Allocate a load at the tail |
| allocSeq | input | SEQW | Sequence number of the allocated load |
| sqEmpty | input | 1 | Store queue is empty at allocation |
| sqTail | input | SQW | Store-queue tail at allocation |
| allocIdx | output | IW | Slot the next allocation will use (load tail) |
| lqFull | output | 1 | DEPTH loads held |
| lqCount | output | IW | Number of loads held |
| headSqIdx | output | SQW | Store index recorded by the oldest load |
| headSqNone | output | 1 | Oldest load recorded an empty store queue |
| addrValid | input | 1 | Post an address into a slot |
| addrIdx | input | IW | Slot receiving the address |
| addrVal | input | AW | Effective address |
| chkValid | input | 1 | Check request |
| chkIsStore | input | 1 | 1: store check, 0: load check |
| chkIdx | input | IW | Load's own slot or store's captured load tail |
| chkAddr | input | AW | Address of the executing access |
| commitValid | input | 1 | Commit request |
| commitSeq | input | SEQW | Youngest committed sequence number |
| squashValid | input | 1 | Squash request |
| squashSeq | input | SEQW | Loads above this number are removed |
| violRead | input | 1 | Consume (clear) the held violator |
| violValid | output | 1 | A violator is held |
| violIdx | output | IW | Slot of the held violator |
| violSeq | output | SEQW | Sequence number of the held violator |
| chkFault | output | 1 | One-cycle pulse: last check recorded a violator |
| violCount | output | CNTW | Number of recorded violations |

## Verification
Properties checked on every cycle:
- the occupancy bound;
- the tail holding still when a full queue refuses an allocation;
- the fault pulse coinciding with a held violator and with a counter step of exactly one;
- a covering squash and an unopposed read both clearing the violator;
- the head freezing during a squash;
- a freshly allocated slot losing its address-valid flag.

Only the bench scenarios can show which loads a scan covers and which one it picks:
- the exclusion of the load's own slot against the inclusion of a store's start slot;
- the coarse address match;
- the refusal of a younger match while an older violator is held;
- bulk commit and squash removing exactly the right set of loads.

// File: rtl/ldq_og_pkg.sv
package ldq_og_pkg;

  // Write strobes passed from control to the entry storage.
  typedef struct packed {
    logic allocWe;  // write a new load at the tail slot
    logic addrWe;   // post an effective address into a slot
  } ldq_strobe_t;

endpackage

// File: rtl/ldq_og_data.sv
module ldq_og_data
  import ldq_og_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int SEQW  = 16,
  parameter int SQW   = 4,
  parameter int GRAN  = 8,
  localparam int RING = DEPTH + 1,
  localparam int IW   = $clog2(RING)
) (
  input  logic            clk,
  input  logic            rstN,
  input  ldq_strobe_t     strobe,
  input  logic [IW-1:0]   tailIdx,
  input  logic [IW-1:0]   headIdx,
  input  logic [SEQW-1:0] allocSeq,
  input  logic [SQW-1:0]  allocSqIdx,
  input  logic            allocSqNone,
  input  logic [IW-1:0]   addrIdx,
  input  logic [AW-1:0]   addrVal,
  input  logic [AW-1:0]   chkAddr,
  input  logic [SEQW-1:0] commitSeq,
  input  logic [SEQW-1:0] squashSeq,
  output logic [RING-1:0] matchVec,
  output logic [RING-1:0] leVec,
  output logic [RING-1:0] gtVec,
  output logic [SEQW-1:0] seqArr [RING],
  output logic [SQW-1:0]  headSqIdx,
  output logic            headSqNone
);

  logic [SEQW-1:0] seqMem   [RING];
  logic [AW-1:0]   addrMem  [RING];
  logic [SQW-1:0]  sqIdxMem [RING];
  logic [RING-1:0] avMem;
  logic [RING-1:0] sqNoneMem;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      avMem     <= '0;
      sqNoneMem <= '0;
      for (int i = 0; i < RING; i++) begin
        seqMem[i]   <= '0;
        addrMem[i]  <= '0;
        sqIdxMem[i] <= '0;
      end
    end else begin
      if (strobe.addrWe) begin
        addrMem[addrIdx] <= addrVal;
        avMem[addrIdx]   <= 1'b1;
      end
      // allocation comes last so it wins on a shared slot
      if (strobe.allocWe) begin
        seqMem[tailIdx]    <= allocSeq;
        avMem[tailIdx]     <= 1'b0;
        sqIdxMem[tailIdx]  <= allocSqIdx;
        sqNoneMem[tailIdx] <= allocSqNone;
      end
    end
  end

  // Per-slot comparators; the control masks them by ring position.
  for (genvar g = 0; g < RING; g++) begin : g_slot
    assign matchVec[g] = avMem[g] && (addrMem[g][AW-1:GRAN] == chkAddr[AW-1:GRAN]);
    assign leVec[g]    = (seqMem[g] <= commitSeq);
    assign gtVec[g]    = (seqMem[g] > squashSeq);
    assign seqArr[g]   = seqMem[g];
  end

  assign headSqIdx  = sqIdxMem[headIdx];
  assign headSqNone = sqNoneMem[headIdx];

  // R6: a newly allocated load starts without a usable address
  p_alloc_clears_addr_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.allocWe |=> !avMem[$past(tailIdx)]);

endmodule

// File: rtl/ldq_og_ctrl.sv
module ldq_og_ctrl
  import ldq_og_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int SEQW  = 16,
  parameter int CNTW  = 16,
  localparam int RING = DEPTH + 1,
  localparam int IW   = $clog2(RING)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            allocValid,
  input  logic            addrValid,
  input  logic            chkValid,
  input  logic            chkIsStore,
  input  logic [IW-1:0]   chkIdx,
  input  logic            commitValid,
  input  logic            squashValid,
  input  logic [SEQW-1:0] squashSeq,
  input  logic            violRead,
  input  logic [RING-1:0] matchVec,
  input  logic [RING-1:0] leVec,
  input  logic [RING-1:0] gtVec,
  input  logic [SEQW-1:0] seqArr [RING],
  output ldq_strobe_t     strobe,
  output logic [IW-1:0]   headIdx,
  output logic [IW-1:0]   tailIdx,
  output logic [IW-1:0]   count,
  output logic            full,
  output logic            violValid,
  output logic [IW-1:0]   violIdx,
  output logic [SEQW-1:0] violSeq,
  output logic            chkFault,
  output logic [CNTW-1:0] violCount
);

  localparam logic [IW:0]   RING_W = (IW+1)'(RING);
  localparam logic [IW-1:0] DEPTH_W = IW'(DEPTH);

  function automatic logic [IW-1:0] ringAdd(input logic [IW-1:0] a, input logic [IW-1:0] b);
    logic [IW:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= RING_W) s = s - RING_W;
    return s[IW-1:0];
  endfunction

  function automatic logic [IW-1:0] ringSub(input logic [IW-1:0] a, input logic [IW-1:0] b);
    logic [IW:0] s;
    if (a >= b) s = {1'b0, a} - {1'b0, b};
    else        s = {1'b0, a} + RING_W - {1'b0, b};
    return s[IW-1:0];
  endfunction

  logic            allocOk;
  logic [RING-1:0] occupied;
  logic [IW-1:0]   nCommit, nSquash;
  logic [IW-1:0]   scanStart, scanLen;
  logic            hit;
  logic [IW-1:0]   pickIdx;
  logic            replace;

  assign full           = (count == DEPTH_W);
  assign allocOk        = allocValid && !full && !squashValid;
  assign strobe.allocWe = allocOk;
  assign strobe.addrWe  = addrValid;

  // Occupancy mask and bulk commit / squash sizes
  always_comb begin
    nCommit = '0;
    nSquash = '0;
    for (int i = 0; i < RING; i++) begin
      occupied[i] = ringSub(IW'(i), headIdx) < count;
      if (commitValid && occupied[i] && leVec[i]) nCommit = nCommit + IW'(1);
      if (occupied[i] && gtVec[i])                nSquash = nSquash + IW'(1);
    end
  end

  // Scan window and oldest-match pick
  assign scanStart = chkIsStore ? chkIdx : ringAdd(chkIdx, IW'(1));
  assign scanLen   = ringSub(tailIdx, scanStart);

  always_comb begin
    hit     = 1'b0;
    pickIdx = '0;
    for (int k = 0; k < RING; k++) begin
      logic [IW-1:0] idx;
      idx = ringAdd(scanStart, IW'(k));
      if (!hit && (IW'(k) < scanLen) && matchVec[idx]) begin
        hit     = 1'b1;
        pickIdx = idx;
      end
    end
  end

  assign replace = chkValid && !squashValid && hit &&
                   (!violValid || (seqArr[pickIdx] < violSeq));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headIdx <= '0;
      tailIdx <= '0;
      count   <= '0;
    end else if (squashValid) begin
      tailIdx <= ringSub(tailIdx, nSquash);
      count   <= count - nSquash;
    end else begin
      headIdx <= ringAdd(headIdx, nCommit);
      tailIdx <= ringAdd(tailIdx, IW'(allocOk));
      count   <= count - nCommit + IW'(allocOk);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      violValid <= 1'b0;
      violIdx   <= '0;
      violSeq   <= '0;
      chkFault  <= 1'b0;
      violCount <= '0;
    end else begin
      chkFault <= replace;
      if (replace) begin
        violValid <= 1'b1;
        violIdx   <= pickIdx;
        violSeq   <= seqArr[pickIdx];
        violCount <= violCount + CNTW'(1);
      end else if (violRead || (squashValid && (squashSeq < violSeq))) begin
        violValid <= 1'b0;
      end
    end
  end

  // R2: occupancy never exceeds capacity
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rstN)
    count <= DEPTH_W);

  // R2: a refused allocation leaves the tail alone
  p_full_holds_tail_r2: assert property (@(posedge clk) disable iff (!rstN)
    (allocValid && full && !squashValid) |=> $stable(tailIdx));

  // R8: a fault pulse always comes with a held violator
  p_fault_has_viol_r8: assert property (@(posedge clk) disable iff (!rstN)
    chkFault |-> violValid);

  // R8: the counter steps by exactly one per fault
  p_fault_counts_r8: assert property (@(posedge clk) disable iff (!rstN)
    chkFault |-> (violCount == $past(violCount) + CNTW'(1)));

  // R10: a covering squash drops the violator
  p_squash_clears_r10: assert property (@(posedge clk) disable iff (!rstN)
    (squashValid && violValid && (squashSeq < violSeq)) |=> !violValid);

  // R11: a read without a competing check clears the violator
  p_read_clears_r11: assert property (@(posedge clk) disable iff (!rstN)
    (violRead && !chkValid) |=> !violValid);

  // R12: a squash cycle retires nothing from the head
  p_squash_freeze_r12: assert property (@(posedge clk) disable iff (!rstN)
    squashValid |=> $stable(headIdx));

endmodule

// File: rtl/ldq_order_guard.sv
module ldq_order_guard
  import ldq_og_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int SEQW  = 16,
  parameter int SQW   = 4,
  parameter int GRAN  = 8,
  parameter int CNTW  = 16,
  localparam int RING = DEPTH + 1,
  localparam int IW   = $clog2(RING)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            allocValid,
  input  logic [SEQW-1:0] allocSeq,
  input  logic            sqEmpty,
  input  logic [SQW-1:0]  sqTail,
  output logic [IW-1:0]   allocIdx,
  output logic            lqFull,
  output logic [IW-1:0]   lqCount,
  output logic [SQW-1:0]  headSqIdx,
  output logic            headSqNone,
  input  logic            addrValid,
  input  logic [IW-1:0]   addrIdx,
  input  logic [AW-1:0]   addrVal,
  input  logic            chkValid,
  input  logic            chkIsStore,
  input  logic [IW-1:0]   chkIdx,
  input  logic [AW-1:0]   chkAddr,
  input  logic            commitValid,
  input  logic [SEQW-1:0] commitSeq,
  input  logic            squashValid,
  input  logic [SEQW-1:0] squashSeq,
  input  logic            violRead,
  output logic            violValid,
  output logic [IW-1:0]   violIdx,
  output logic [SEQW-1:0] violSeq,
  output logic            chkFault,
  output logic [CNTW-1:0] violCount
);

  ldq_strobe_t     strobe;
  logic [IW-1:0]   headIdx, tailIdx;
  logic [RING-1:0] matchVec, leVec, gtVec;
  logic [SEQW-1:0] seqArr [RING];

  assign allocIdx = tailIdx;

  ldq_og_ctrl #(.DEPTH(DEPTH), .SEQW(SEQW), .CNTW(CNTW)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .allocValid(allocValid), .addrValid(addrValid),
    .chkValid(chkValid), .chkIsStore(chkIsStore), .chkIdx(chkIdx),
    .commitValid(commitValid), .squashValid(squashValid), .squashSeq(squashSeq),
    .violRead(violRead),
    .matchVec(matchVec), .leVec(leVec), .gtVec(gtVec), .seqArr(seqArr),
    .strobe(strobe), .headIdx(headIdx), .tailIdx(tailIdx),
    .count(lqCount), .full(lqFull),
    .violValid(violValid), .violIdx(violIdx), .violSeq(violSeq),
    .chkFault(chkFault), .violCount(violCount)
  );

  ldq_og_data #(.DEPTH(DEPTH), .AW(AW), .SEQW(SEQW), .SQW(SQW), .GRAN(GRAN)) data_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .tailIdx(tailIdx), .headIdx(headIdx),
    .allocSeq(allocSeq), .allocSqIdx(sqTail), .allocSqNone(sqEmpty),
    .addrIdx(addrIdx), .addrVal(addrVal), .chkAddr(chkAddr),
    .commitSeq(commitSeq), .squashSeq(squashSeq),
    .matchVec(matchVec), .leVec(leVec), .gtVec(gtVec), .seqArr(seqArr),
    .headSqIdx(headSqIdx), .headSqNone(headSqNone)
  );

endmodule

// File: tb/ldq_order_guard_tb.sv
module ldq_order_guard_tb_top;

  localparam int DEPTH = 8;
  localparam int RING  = DEPTH + 1;
  localparam int IW    = 4;
  localparam int AW    = 32;
  localparam int SEQW  = 16;
  localparam int SQW   = 4;
  localparam int CNTW  = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic allocValid, sqEmpty, addrValid, chkValid, chkIsStore;
  logic commitValid, squashValid, violRead;
  logic [SEQW-1:0] allocSeq, commitSeq, squashSeq;
  logic [SQW-1:0]  sqTail;
  logic [IW-1:0]   addrIdx, chkIdx;
  logic [AW-1:0]   addrVal, chkAddr;
  logic [IW-1:0]   allocIdx, lqCount, violIdx;
  logic            lqFull, headSqNone, violValid, chkFault;
  logic [SQW-1:0]  headSqIdx;
  logic [SEQW-1:0] violSeq;
  logic [CNTW-1:0] violCount;

  always #2 clk = ~clk;  // 250 MHz

  ldq_order_guard dut_i (
    .clk(clk), .rstN(rstN),
    .allocValid(allocValid), .allocSeq(allocSeq), .sqEmpty(sqEmpty), .sqTail(sqTail),
    .allocIdx(allocIdx), .lqFull(lqFull), .lqCount(lqCount),
    .headSqIdx(headSqIdx), .headSqNone(headSqNone),
    .addrValid(addrValid), .addrIdx(addrIdx), .addrVal(addrVal),
    .chkValid(chkValid), .chkIsStore(chkIsStore), .chkIdx(chkIdx), .chkAddr(chkAddr),
    .commitValid(commitValid), .commitSeq(commitSeq),
    .squashValid(squashValid), .squashSeq(squashSeq),
    .violRead(violRead),
    .violValid(violValid), .violIdx(violIdx), .violSeq(violSeq),
    .chkFault(chkFault), .violCount(violCount)
  );

  // Reference model
  int mSeq [RING];
  int mAddr [RING];
  bit mAv [RING];
  int mSqIdx [RING];
  bit mSqNone [RING];
  int mHead, mTail, mCnt;
  bit mVV, mFault;
  int mVIdx, mVSeq, mVCnt;
  int nextSeq = 1;
  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  function automatic int wr(int x);
    return ((x % RING) + RING) % RING;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic idle();
    allocValid = 0; sqEmpty = 0; sqTail = '0; allocSeq = '0;
    addrValid = 0; addrIdx = '0; addrVal = '0;
    chkValid = 0; chkIsStore = 0; chkIdx = '0; chkAddr = '0;
    commitValid = 0; commitSeq = '0; squashValid = 0; squashSeq = '0;
    violRead = 0;
  endtask

  // Advance the model from the inputs currently driven.
  task automatic modelStep();
    int pre;
    pre = mCnt;
    if (squashValid) begin
      while (mCnt > 0 && mSeq[wr(mTail - 1)] > int'(squashSeq)) begin
        mTail = wr(mTail - 1);
        mCnt--;
      end
      if (mVV && (int'(squashSeq) < mVSeq || violRead)) mVV = 0;
      mFault = 0;
    end else begin
      bit found;
      int pick, j;
      found = 0; pick = 0;
      if (chkValid) begin
        j = chkIsStore ? int'(chkIdx) : wr(int'(chkIdx) + 1);
        while (j != mTail) begin
          if (mAv[j] && ((mAddr[j] >>> 8) == (int'(chkAddr) >>> 8))) begin
            found = 1; pick = j; break;
          end
          j = wr(j + 1);
        end
      end
      mFault = found && (!mVV || mSeq[pick] < mVSeq);
      if (mFault) begin
        mVV = 1; mVIdx = pick; mVSeq = mSeq[pick]; mVCnt++;
      end else if (violRead) mVV = 0;
      if (commitValid)
        while (mCnt > 0 && mSeq[mHead] <= int'(commitSeq)) begin
          mHead = wr(mHead + 1);
          mCnt--;
        end
    end
    if (addrValid) begin
      mAv[addrIdx] = 1;
      mAddr[addrIdx] = int'(addrVal);
    end
    if (!squashValid && allocValid && pre < DEPTH) begin
      mSeq[mTail] = int'(allocSeq);
      mAv[mTail] = 0;
      mSqIdx[mTail] = int'(sqTail);
      mSqNone[mTail] = sqEmpty;
      mTail = wr(mTail + 1);
      mCnt++;
    end
  endtask

  task automatic compareAll(string req);
    chk(req, "count", int'(lqCount), mCnt);
    chk(req, "full", int'(lqFull), int'(mCnt == DEPTH));
    chk(req, "allocIdx", int'(allocIdx), mTail);
    chk(req, "violValid", int'(violValid), int'(mVV));
    if (mVV) begin
      chk(req, "violIdx", int'(violIdx), mVIdx);
      chk(req, "violSeq", int'(violSeq), mVSeq);
    end
    chk(req, "chkFault", int'(chkFault), int'(mFault));
    chk(req, "violCount", int'(violCount), mVCnt);
    if (mCnt > 0) begin
      chk(req, "headSqNone", int'(headSqNone), int'(mSqNone[mHead]));
      if (!mSqNone[mHead]) chk(req, "headSqIdx", int'(headSqIdx), mSqIdx[mHead]);
    end
  endtask

  task automatic step(string req);
    modelStep();
    @(posedge clk);
    @(negedge clk);
    compareAll(req);
    idle();
  endtask

  task automatic doAlloc(bit empty, int tailv);
    allocValid = 1; allocSeq = SEQW'(nextSeq); nextSeq++;
    sqEmpty = empty; sqTail = SQW'(tailv);
  endtask

  task automatic postAddr(int slot, int a);
    addrValid = 1; addrIdx = IW'(slot); addrVal = AW'(a);
  endtask

  task automatic doCheck(bit st, int idx, int a);
    chkValid = 1; chkIsStore = st; chkIdx = IW'(idx); chkAddr = AW'(a);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    int h;
    void'($urandom(32'd1234));
    idle();
    for (int i = 0; i < RING; i++) begin
      mSeq[i] = 0; mAddr[i] = 0; mAv[i] = 0; mSqIdx[i] = 0; mSqNone[i] = 0;
    end
    mHead = 0; mTail = 0; mCnt = 0; mVV = 0; mFault = 0; mVIdx = 0; mVSeq = 0; mVCnt = 0;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    compareAll("R1");

    // R3: none marker when the store queue is empty, else the store tail
    doAlloc(1, 0);  step("R3");
    doAlloc(0, 5);  step("R3");
    commitValid = 1; commitSeq = SEQW'(mSeq[mHead]); step("R3");

    // R2: fill to capacity, then an allocation while full is ignored
    for (int i = 0; i < DEPTH - 1; i++) begin doAlloc(0, i); step("R2"); end
    doAlloc(0, 9); step("R2");
    h = mHead;

    // R6 / R4: younger load with a valid address in the same 256-byte block
    postAddr(wr(h + 3), 32'h2010); step("R6");
    doCheck(0, wr(h + 1), 32'h20F0); step("R6");
    violRead = 1; step("R11");
    doCheck(0, wr(h + 3), 32'h2000); step("R4");      // own slot excluded
    doCheck(0, wr(h + 1), 32'h2110); step("R6");      // bits above 7 differ
    // R5: a store scan includes its start slot
    doCheck(1, wr(h + 3), 32'h2000); step("R5");
    // R7: younger match is refused, older one replaces
    postAddr(wr(h + 2), 32'h3000); step("R7");
    postAddr(wr(h + 6), 32'h3000); step("R7");
    doCheck(1, wr(h + 5), 32'h3000); step("R7");
    doCheck(1, wr(h + 1), 32'h3000); step("R8");
    // R11: read with a simultaneous older detection keeps the new violator
    postAddr(wr(h + 1), 32'h4000); step("R11");
    doCheck(1, h, 32'h4000); violRead = 1; step("R11");
    // R12: squash that removes nothing blocks alloc, commit and check
    squashValid = 1; squashSeq = SEQW'(nextSeq + 10);
    doAlloc(0, 1); commitValid = 1; commitSeq = SEQW'(nextSeq);
    doCheck(1, h, 32'h4000); step("R12");
    // R10: partial squash keeps the violator, covering squash clears it
    squashValid = 1; squashSeq = SEQW'(mSeq[wr(h + 1)]); step("R10");
    squashValid = 1; squashSeq = SEQW'(mSeq[h]); step("R10");
    // R9: commit bound below the head removes nothing, then bulk commit
    commitValid = 1; commitSeq = SEQW'(mSeq[mHead] - 1); step("R9");
    for (int i = 0; i < 4; i++) begin doAlloc(0, i); step("R9"); end
    commitValid = 1; commitSeq = SEQW'(nextSeq); step("R9");

    // Constrained random mix
    for (int it = 0; it < 3000; it++) begin
      if ($urandom % 2 == 0) doAlloc(bit'($urandom % 4 == 0), int'($urandom % 16));
      if (mCnt > 0 && $urandom % 3 == 0)
        postAddr(wr(mHead + int'($urandom % mCnt)),
                 32'h1000 + int'(($urandom % 4) << 8) + int'($urandom % 256));
      if ($urandom % 3 == 0) begin
        if ($urandom % 2 == 0 && mCnt > 0)
          doCheck(0, wr(mHead + int'($urandom % mCnt)), 32'h1000 + int'(($urandom % 4) << 8));
        else
          doCheck(1, wr(mHead + int'($urandom % (mCnt + 1))), 32'h1000 + int'(($urandom % 4) << 8) + 7);
      end
      if (mCnt > 0 && $urandom % 7 == 0) begin
        commitValid = 1; commitSeq = SEQW'(mSeq[wr(mHead + int'($urandom % mCnt))]);
      end
      if ($urandom % 25 == 0) begin
        squashValid = 1;
        squashSeq = (mCnt > 0) ? SEQW'(mSeq[wr(mHead + int'($urandom % mCnt))] - int'($urandom % 2))
                               : SEQW'(nextSeq);
      end
      if ($urandom % 10 == 0) violRead = 1;
      step("R7");
    end

    done = 1;
    summary();
    $finish;
  end

endmodule